// File: doc/BRIEF.md
# Differential and CCK Chip Phase Mapper

This block turns grouped, already-scrambled transmit bits into chip-rate I/Q phases for a direct-sequence spread-spectrum transmitter. Each accepted input symbol carries a rate tag and up to eight bits. At the two low rates the bits set a differential phase step, DBPSK with one bit or DQPSK with two. The resulting symbol phase is then spread by an 11-chip Barker word. At the two high rates a nibble or a byte becomes one 8-chip complementary code keying (CCK) symbol.

A single differential phase accumulator is shared by every rate. When the rate tag changes from a header symbol to a payload symbol, the first payload symbol is referenced to the phase of the last header symbol, with no jump. A start-of-packet flag clears the reference. A rotation-reverse input mirrors the sense of the Gray-coded phase steps. The block emits one chip per clock, as a 2-bit phase index and as signed ±1 I and Q values with a valid strobe. A symbol offered on the last chip of the one in flight is taken without a gap.

Top module: `dsss_chip_mapper`

## Requirements
- R1: After reset, `chip_valid` is 0, `sym_ready` is 1 and both `chip_i` and `chip_q` are 0.
- R2: Rate codes are 0 = 1 Mbps, 1 = 2 Mbps, 2 = 5.5 Mbps and 3 = 11 Mbps. Codes 0 and 1 produce 11 chips per symbol and codes 2 and 3 produce 8. A symbol is accepted when `sym_valid` and `sym_ready` are both high. `sym_ready` is high only when idle or on the final chip. Back-to-back symbols produce chips on consecutive cycles with no gap, starting the cycle after acceptance.
- R3: At rate 0, bit d0 = `sym_bits[0]` adds 0 (d0 = 0) or 2 (d0 = 1) to the phase reference. Phases are indices modulo 4, and each step is 90°.
- R4: At rate 1, the dibit (d0, d1) = (`sym_bits[0]`, `sym_bits[1]`) steps the phase by 00 → 0, 01 → +1, 11 → +2, 10 → +3 (−90°).
- R5: With `rot_rev` = 1, every dibit lookup swaps the +1 and +3 entries. This applies to the DQPSK step, to the CCK differential term and to the 11 Mbps spreading phases.
- R6: A Barker symbol with phase p emits chip n (n = 0 first) with phase p, or p + 2 where the word +1 −1 +1 +1 −1 +1 +1 +1 −1 −1 −1 has −1.
- R7: A CCK symbol emits, first to last, φ1+φ2+φ3+φ4, φ1+φ3+φ4, φ1+φ2+φ4, φ1+φ4+2, φ1+φ2+φ3, φ1+φ3, φ1+φ2+2, φ1.
- R8: At rate 2, φ1 steps by the dibit of (d0, d1). φ2 = 1 + 2·d2, φ3 = 0 and φ4 = 2·d3.
- R9: At rate 3, φ1 steps by the dibit of (d0, d1). φ2, φ3 and φ4 are the dibit lookups of (d2, d3), (d4, d5) and (d6, d7).
- R10: CCK symbols are counted from 0 after `sym_first` or after any Barker symbol. Odd-numbered CCK symbols add an extra 2 to φ1.
- R11: The phase reference is the last symbol's phase: p at 1/2 Mbps, φ1 for CCK. It carries across rate changes. With `sym_first` = 1 the reference is 0 for that symbol.
- R12: Chip phase index 0/1/2/3 drives (I,Q) = (+1,+1)/(−1,+1)/(−1,−1)/(+1,−1). Outside valid chips, `chip_phase`, `chip_i` and `chip_q` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_valid | input | 1 | Input symbol offered |
| sym_first | input | 1 | Symbol starts a packet; reference and CCK count cleared |
| sym_rate | input | 2 | Rate code of the offered symbol |
| sym_bits | input | 8 | Symbol bits, bit k = d_k, d0 first in time |
| rot_rev | input | 1 | Reverse sense of dibit phase steps |
| sym_ready | output | 1 | Offered symbol taken at this edge |
| chip_valid | output | 1 | Chip output valid |
| chip_phase | output | 2 | Chip phase index, 90° per step |
| chip_i | output | 2 | Signed I value, ±1 or 0 |
| chip_q | output | 2 | Signed Q value, ±1 or 0 |

## Verification
The hardest case to reach from the ports is the hand-over of the phase reference and of the CCK odd/even count. This must happen across rate changes, under a packet restart and while symbols are offered on the last chip of the previous symbol. The stimulus sweeps every input value of all four rates, with each rotation sense, in one gapless stream. It then restarts a packet directly into CCK and drops back to Barker rates mid-stream, so every chip of the stream depends on the full history of references.

// File: rtl/dsss_map_pkg.sv
package dsss_map_pkg;
  localparam int PH_W = 2;
  typedef logic [PH_W-1:0] phase_t;

  typedef enum logic [1:0] {
    RATE_1M  = 2'd0,
    RATE_2M  = 2'd1,
    RATE_5M5 = 2'd2,
    RATE_11M = 2'd3
  } rate_e;

  typedef struct packed {
    phase_t p1;
    phase_t p2;
    phase_t p3;
    phase_t p4;
  } sym_ph_t;

  // Gray-coded dibit step; first bit in time is the upper select bit
  function automatic phase_t dibit_step(input logic d_early, input logic d_late,
                                        input logic rev);
    phase_t r;
    case ({d_early, d_late})
      2'b00:   r = 2'd0;
      2'b01:   r = rev ? 2'd3 : 2'd1;
      2'b11:   r = 2'd2;
      default: r = rev ? 2'd1 : 2'd3;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/dsss_sym_phase.sv
module dsss_sym_phase
  import dsss_map_pkg::*;
#(
  parameter int BITS_W = 8
) (
  input  rate_e             rate,
  input  logic [BITS_W-1:0] bits,
  input  phase_t            ref_ph,
  input  logic              first,
  input  logic              odd_in,
  input  logic              rev,
  output sym_ph_t           ph,
  output logic              is_cck
);
  phase_t base;
  phase_t step;
  logic   eff_odd;

  always_comb begin
    base    = first ? phase_t'(0) : ref_ph;
    eff_odd = first ? 1'b0 : odd_in;
    is_cck  = (rate == RATE_5M5) || (rate == RATE_11M);
    step    = dibit_step(bits[0], bits[1], rev);
    ph      = '0;
    case (rate)
      RATE_1M: begin
        ph.p1 = base + (bits[0] ? phase_t'(2) : phase_t'(0));
      end
      RATE_2M: begin
        ph.p1 = base + step;
      end
      RATE_5M5: begin
        ph.p1 = base + step + (eff_odd ? phase_t'(2) : phase_t'(0));
        ph.p2 = bits[2] ? phase_t'(3) : phase_t'(1);
        ph.p3 = phase_t'(0);
        ph.p4 = bits[3] ? phase_t'(2) : phase_t'(0);
      end
      default: begin
        ph.p1 = base + step + (eff_odd ? phase_t'(2) : phase_t'(0));
        ph.p2 = dibit_step(bits[2], bits[3], rev);
        ph.p3 = dibit_step(bits[4], bits[5], rev);
        ph.p4 = dibit_step(bits[6], bits[7], rev);
      end
    endcase
  end
endmodule

// File: rtl/dsss_chip_seq.sv
module dsss_chip_seq #(
  parameter int BARKER_LEN = 11,
  parameter int CCK_LEN    = 8,
  localparam int MAX_LEN   = (BARKER_LEN > CCK_LEN) ? BARKER_LEN : CCK_LEN,
  localparam int CNT_W     = $clog2(MAX_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sym_valid,
  input  logic             in_cck,
  output logic             sym_ready,
  output logic             accept,
  output logic             busy,
  output logic             cur_cck,
  output logic             last,
  output logic [CNT_W-1:0] idx
);
  logic             busy_n;
  logic             cck_n;
  logic [CNT_W-1:0] idx_n;

  always_comb begin
    last      = busy && (cur_cck ? (idx == CNT_W'(CCK_LEN - 1))
                                 : (idx == CNT_W'(BARKER_LEN - 1)));
    sym_ready = !busy || last;
    accept    = sym_valid && sym_ready;
    busy_n    = busy;
    cck_n     = cur_cck;
    idx_n     = idx;
    if (accept) begin
      busy_n = 1'b1;
      cck_n  = in_cck;
      idx_n  = '0;
    end else if (busy) begin
      if (last) busy_n = 1'b0;
      else      idx_n  = idx + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cur_cck <= 1'b0;
      idx     <= '0;
    end else begin
      busy    <= busy_n;
      cur_cck <= cck_n;
      idx     <= idx_n;
    end
  end

  // R2: a symbol in flight keeps the chip stream running until its final chip
  a_r2_no_early_stop: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !last |=> busy);
  // R2: no new symbol is taken before the final chip
  a_r2_ready_only_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !last |-> !sym_ready);
  // R2: chip index never passes the symbol length
  a_r2_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (idx < CNT_W'(MAX_LEN)));
endmodule

// File: rtl/dsss_chip_phase.sv
module dsss_chip_phase
  import dsss_map_pkg::*;
#(
  parameter int                  BARKER_LEN = 11,
  parameter logic [BARKER_LEN-1:0] BARKER_NEG = 11'b11100010010,
  parameter int                  CNT_W      = 4
) (
  input  logic             cck,
  input  logic [CNT_W-1:0] idx,
  input  sym_ph_t          ph,
  output phase_t           chip_ph
);
  phase_t cck_ph;
  phase_t bark_ph;
  logic   neg_bark;
  logic   neg_cck;

  always_comb begin
    neg_bark = (int'(idx) < BARKER_LEN) ? BARKER_NEG[idx] : 1'b0;
    bark_ph  = ph.p1 + (neg_bark ? phase_t'(2) : phase_t'(0));
    // chips 3 and 6 carry an extra half turn
    neg_cck  = (idx == CNT_W'(3)) || (idx == CNT_W'(6));
    cck_ph   = ph.p1
             + (idx[0] ? phase_t'(0) : ph.p2)
             + (idx[1] ? phase_t'(0) : ph.p3)
             + (idx[2] ? phase_t'(0) : ph.p4)
             + (neg_cck ? phase_t'(2) : phase_t'(0));
    chip_ph  = cck ? cck_ph : bark_ph;
  end
endmodule

// File: rtl/dsss_chip_mapper.sv
module dsss_chip_mapper
  import dsss_map_pkg::*;
#(
  parameter int BITS_W     = 8,
  parameter int BARKER_LEN = 11,
  parameter int CCK_LEN    = 8,
  parameter logic [BARKER_LEN-1:0] BARKER_NEG = 11'b11100010010,
  localparam int MAX_LEN   = (BARKER_LEN > CCK_LEN) ? BARKER_LEN : CCK_LEN,
  localparam int CNT_W     = $clog2(MAX_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sym_valid,
  input  logic              sym_first,
  input  logic [1:0]        sym_rate,
  input  logic [BITS_W-1:0] sym_bits,
  input  logic              rot_rev,
  output logic              sym_ready,
  output logic              chip_valid,
  output logic [1:0]        chip_phase,
  output logic signed [1:0] chip_i,
  output logic signed [1:0] chip_q
);
  sym_ph_t          cur_ph;
  sym_ph_t          new_ph;
  sym_ph_t          cur_ph_n;
  logic             cck_odd;
  logic             cck_odd_n;
  logic             in_cck;
  logic             accept;
  logic             busy;
  logic             cur_cck;
  logic             last;
  logic [CNT_W-1:0] idx;
  phase_t           raw_ph;

  dsss_sym_phase #(.BITS_W(BITS_W)) u_sym (
    .rate   (rate_e'(sym_rate)),
    .bits   (sym_bits),
    .ref_ph (cur_ph.p1),
    .first  (sym_first),
    .odd_in (cck_odd),
    .rev    (rot_rev),
    .ph     (new_ph),
    .is_cck (in_cck)
  );

  dsss_chip_seq #(.BARKER_LEN(BARKER_LEN), .CCK_LEN(CCK_LEN)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .sym_valid (sym_valid),
    .in_cck    (in_cck),
    .sym_ready (sym_ready),
    .accept    (accept),
    .busy      (busy),
    .cur_cck   (cur_cck),
    .last      (last),
    .idx       (idx)
  );

  dsss_chip_phase #(.BARKER_LEN(BARKER_LEN), .BARKER_NEG(BARKER_NEG),
                    .CNT_W(CNT_W)) u_chip (
    .cck     (cur_cck),
    .idx     (idx),
    .ph      (cur_ph),
    .chip_ph (raw_ph)
  );

  // shared differential accumulator (p1) plus spreading phases
  always_comb begin
    cur_ph_n  = cur_ph;
    cck_odd_n = cck_odd;
    if (accept) begin
      cur_ph_n  = new_ph;
      cck_odd_n = in_cck ? !(sym_first ? 1'b0 : cck_odd) : 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_ph  <= '0;
      cck_odd <= 1'b0;
    end else begin
      cur_ph  <= cur_ph_n;
      cck_odd <= cck_odd_n;
    end
  end

  always_comb begin
    chip_valid = busy;
    chip_phase = busy ? raw_ph : 2'd0;
    chip_i     = 2'sd0;
    chip_q     = 2'sd0;
    if (busy) begin
      chip_i = (raw_ph == 2'd1 || raw_ph == 2'd2) ? -2'sd1 : 2'sd1;
      chip_q = raw_ph[1] ? -2'sd1 : 2'sd1;
    end
  end

  // R11: the reference phase moves only when a symbol is taken
  a_r11_ref_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(cur_ph.p1));
  // R6: first Barker chip equals the symbol phase held in the accumulator
  a_r6_barker_head: assert property (@(posedge clk) disable iff (!rst_n)
    chip_valid && !cur_cck && idx == '0 |-> chip_phase == cur_ph.p1);
  // R7: final CCK chip equals the symbol's reference phase
  a_r7_cck_tail: assert property (@(posedge clk) disable iff (!rst_n)
    chip_valid && cur_cck && idx == CNT_W'(CCK_LEN - 1) |-> chip_phase == cur_ph.p1);
  // R10: a Barker symbol restarts the CCK odd/even count
  a_r10_parity_clear: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !in_cck |=> !cck_odd);
  // R12: outputs are quiet between chips
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_valid |-> chip_i == 2'sd0 && chip_q == 2'sd0 && chip_phase == 2'd0);
endmodule

// File: tb/dsss_chip_mapper_bench.sv
module dsss_chip_mapper_bench;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              sym_valid = 1'b0;
  logic              sym_first = 1'b0;
  logic [1:0]        sym_rate = 2'd0;
  logic [7:0]        sym_bits = 8'd0;
  logic              rot_rev = 1'b0;
  logic              sym_ready;
  logic              chip_valid;
  logic [1:0]        chip_phase;
  logic signed [1:0] chip_i;
  logic signed [1:0] chip_q;

  int vectors = 0;
  int fails   = 0;
  int cyc     = 0;
  int ref_ph  = 0;
  int odd     = 0;
  int exp_ph  [0:16383];
  int exp_req [0:16383];
  int pop_cyc [0:16383];
  int wr = 0;
  int rd = 0;

  always #2 clk = ~clk;

  dsss_chip_mapper u_dsss_chip_mapper (
    .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_first(sym_first),
    .sym_rate(sym_rate), .sym_bits(sym_bits), .rot_rev(rot_rev),
    .sym_ready(sym_ready), .chip_valid(chip_valid), .chip_phase(chip_phase),
    .chip_i(chip_i), .chip_q(chip_q));

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int gray(input int a, input int b, input int rev);
    if (a == 0 && b == 0) return 0;
    if (a == 0 && b == 1) return rev ? 3 : 1;
    if (a == 1 && b == 1) return 2;
    return rev ? 1 : 3;
  endfunction

  // chip monitor: R6, R7, R12 plus per-symbol tags carried in exp_req
  always @(negedge clk) begin
    if (rst_n && chip_valid) begin
      if (rd == wr) begin
        check(0, "R2 chip without symbol", 1, 0);
      end else begin
        int e;
        int ei;
        int eq;
        string tag;
        e   = exp_ph[rd];
        ei  = (e == 1 || e == 2) ? -1 : 1;
        eq  = (e >= 2) ? -1 : 1;
        case (exp_req[rd])
          0: tag = "R3 dbpsk/R6 barker";
          1: tag = "R4 dqpsk/R5 rot/R6 barker";
          2: tag = "R8 cck5m5/R7/R10/R11";
          default: tag = "R9 cck11m/R7/R10/R11";
        endcase
        check(int'(chip_phase) == e, tag, int'(chip_phase), e);
        check(int'(chip_i) == ei && int'(chip_q) == eq, "R12 iq map",
              int'(chip_i) * 4 + int'(chip_q), ei * 4 + eq);
        pop_cyc[rd] = cyc;
        rd++;
      end
    end
  end

  task automatic send(input int rate, input int bits, input int first, input int rev);
    int base;
    int p1;
    int p2;
    int p3;
    int p4;
    int barker [11] = '{1, -1, 1, 1, -1, 1, 1, 1, -1, -1, -1};
    int d [8];
    @(negedge clk);
    sym_valid = 1'b1;
    sym_rate  = 2'(rate);
    sym_bits  = 8'(bits);
    sym_first = 1'(first);
    rot_rev   = 1'(rev);
    while (!sym_ready) @(negedge clk);
    for (int k = 0; k < 8; k++) d[k] = (bits >> k) & 1;
    base = first ? 0 : ref_ph;
    if (first) odd = 0;
    if (rate < 2) begin
      odd = 0;
      p1  = (rate == 0) ? (base + 2 * d[0]) % 4 : (base + gray(d[0], d[1], rev)) % 4;
      for (int n = 0; n < 11; n++) begin
        exp_ph[wr]  = (p1 + (barker[n] < 0 ? 2 : 0)) % 4;
        exp_req[wr] = rate;
        wr++;
      end
    end else begin
      p1 = (base + gray(d[0], d[1], rev) + 2 * odd) % 4;
      odd = 1 - odd;
      if (rate == 2) begin
        p2 = 1 + 2 * d[2]; p3 = 0; p4 = 2 * d[3];
      end else begin
        p2 = gray(d[2], d[3], rev); p3 = gray(d[4], d[5], rev); p4 = gray(d[6], d[7], rev);
      end
      exp_ph[wr+0] = (p1 + p2 + p3 + p4) % 4;
      exp_ph[wr+1] = (p1 + p3 + p4) % 4;
      exp_ph[wr+2] = (p1 + p2 + p4) % 4;
      exp_ph[wr+3] = (p1 + p4 + 2) % 4;
      exp_ph[wr+4] = (p1 + p2 + p3) % 4;
      exp_ph[wr+5] = (p1 + p3) % 4;
      exp_ph[wr+6] = (p1 + p2 + 2) % 4;
      exp_ph[wr+7] = p1;
      for (int n = 0; n < 8; n++) exp_req[wr+n] = rate;
      wr += 8;
    end
    ref_ph = p1;
  endtask

  task automatic drain();
    @(negedge clk);
    sym_valid = 1'b0;
    for (int k = 0; k < 40 && rd != wr; k++) @(negedge clk);
    check(rd == wr, "R2 all chips emitted", rd, wr);
  endtask

  initial begin
    int t0;
    int t1;
    for (int k = 0; k < 150000; k++) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int s0;
    int s1;
    repeat (3) @(negedge clk);
    check(chip_valid == 1'b0, "R1 valid low in reset", int'(chip_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(chip_valid == 1'b0, "R1 valid low after reset", int'(chip_valid), 0);
    check(sym_ready == 1'b1, "R1 ready after reset", int'(sym_ready), 1);
    check(chip_i == 2'sd0 && chip_q == 2'sd0, "R1 iq zero", int'(chip_i), 0);

    for (int rev = 0; rev < 2; rev++) begin
      s0 = wr;
      send(0, 1, 1, rev);
      for (int v = 0; v < 2; v++)   send(0, v, 0, rev);
      for (int v = 0; v < 4; v++)   send(1, v, 0, rev);
      for (int v = 0; v < 16; v++)  send(2, v, 0, rev);
      for (int v = 0; v < 256; v++) send(3, v, 0, rev);
      for (int v = 0; v < 4; v++)   send(1, 3 - v, 0, rev);
      for (int v = 0; v < 5; v++)   send(3, v * 37, 0, rev);
      send(0, 1, 0, rev);
      for (int v = 0; v < 3; v++)   send(2, v * 5, 0, rev);
      s1 = wr - 1;
      drain();
      // R2: gapless stream across the whole sweep
      check(pop_cyc[s1] - pop_cyc[s0] == s1 - s0, "R2 gapless back-to-back",
            pop_cyc[s1] - pop_cyc[s0], s1 - s0);
      // R11: packet restart straight into CCK, then into a Barker symbol
      send(3, 8'hB4, 1, rev);
      send(3, 8'h4B, 0, rev);
      send(0, 0, 0, rev);
      send(2, 8'h0F, 1, rev);
      drain();
    end
    @(negedge clk);
    check(chip_valid == 1'b0 && chip_i == 2'sd0, "R12 quiet when idle", int'(chip_valid), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule